// File: doc/BRIEF.md
# Memory-mapped console I/O decoder

This block sits on a simple processor load/store bus, between the processor and main memory. Every request whose address has all of its upper sixteen bits set is claimed as I/O. Such a request never reaches memory. It is served by four console registers instead, and a load from one of them raises a dedicated I/O read strobe. Requests outside that window are forwarded to the memory side unchanged.

The keyboard side is a valid/ready byte port feeding a one-byte holding register. The display side is a valid/ready byte port driven from a one-byte output register. Software polls a ready bit in each control register before it reads a key or writes a character.

All bus-facing outputs are registered. A request presented in cycle T shows its memory strobe, or its I/O strobe with read data, in cycle T+1.

Top module: `console_mmio`

## Requirements
- R1: A request whose address bits [31:16] are all one never asserts mem_rd or mem_wr. A read there asserts io_rd in the following cycle.
- R2: A read or write outside the window asserts mem_rd or mem_wr one cycle later, with mem_addr equal to the request address. A write also presents its data on mem_wdata. io_rd stays low for such a request.
- R3: A read of 0xffff0004 (key data) returns the held key byte in io_rdata[7:0] with bits [31:8] zero, and clears the key-available bit. With no byte held, it returns zero.
- R4: A read of 0xffff0000 (key status) returns 1 in bit 0 when a key byte is held, and 0 otherwise. All other bits are 0.
- R5: kbd_ready is high exactly when no key byte is held. A byte is captured on a cycle with kbd_valid and kbd_ready both high. While a byte is held, offered bytes are not taken and the held byte is kept.
- R6: A read of 0xffff0008 (display status) returns 1 in bit 0 when the display side is idle. A write to 0xffff000c (display data) while idle puts wdata[7:0] on dsp_data, with dsp_valid high from the next cycle. The status bit reads 0 until a cycle with dsp_valid and dsp_ready both high.
- R7: A write to display data while a byte is still pending is dropped, and dsp_data keeps the pending byte.
- R8: Reads of display data, and of any other window offset not listed above, return zero. Writes to either status register or to an unlisted offset change no state.
- R9: After reset, mem_rd, mem_wr, io_rd and dsp_valid are low, io_rdata is zero and kbd_ready is high.
- R10: io_rdata is zero in every cycle in which io_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 32 | Request byte address |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request |
| cpu_wdata | input | 32 | Store data |
| mem_rd | output | 1 | Forwarded memory read strobe |
| mem_wr | output | 1 | Forwarded memory write strobe |
| mem_addr | output | 32 | Forwarded memory address |
| mem_wdata | output | 32 | Forwarded memory write data |
| io_rd | output | 1 | I/O read strobe |
| io_rdata | output | 32 | I/O read data, zero-extended byte or status |
| kbd_valid | input | 1 | Keyboard byte offered |
| kbd_data | input | 8 | Keyboard byte |
| kbd_ready | output | 1 | Key holding register empty |
| dsp_valid | output | 1 | Display byte pending |
| dsp_data | output | 8 | Display byte |
| dsp_ready | input | 1 | Display accepts byte |

## Verification
The bound checker watches several rules on every cycle:
- window requests never raise a memory strobe;
- outside requests are forwarded with their address;
- read data is zero whenever no I/O read is signalled, and has its upper bits clear when one is;
- a full key register keeps kbd_ready low until its data is read;
- a pending display byte stays stable until it is accepted.

Only the bench's scenarios can show the rest:
- what each register actually returns;
- that a key byte offered while the holding register is full is refused;
- that a display write landing on a pending byte is dropped;
- that stores to status or unlisted offsets leave the state untouched.

// File: rtl/conio_pkg.sv
package conio_pkg;

  // Register offsets within the I/O window; software depends on these.
  localparam int unsigned OFS_KEY_STAT = 32'h0000_0000;
  localparam int unsigned OFS_KEY_DATA = 32'h0000_0004;
  localparam int unsigned OFS_DSP_STAT = 32'h0000_0008;
  localparam int unsigned OFS_DSP_DATA = 32'h0000_000c;

  typedef enum logic [2:0] {
    SEL_NONE     = 3'd0,
    SEL_KEY_STAT = 3'd1,
    SEL_KEY_DATA = 3'd2,
    SEL_DSP_STAT = 3'd3,
    SEL_DSP_DATA = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic     in_window;
    reg_sel_e sel;
  } decode_t;

endpackage

// File: rtl/conio_decode.sv
module conio_decode
  import conio_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);

  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [TAG_W-1:0]    tag;
  logic [WIN_BITS-1:0] ofs;

  assign tag = addr[ADDR_W-1:WIN_BITS];
  assign ofs = addr[WIN_BITS-1:0];

  always_comb begin
    dec.in_window = &tag;
    dec.sel       = SEL_NONE;
    if (dec.in_window) begin
      if (ofs == WIN_BITS'(OFS_KEY_STAT))      dec.sel = SEL_KEY_STAT;
      else if (ofs == WIN_BITS'(OFS_KEY_DATA)) dec.sel = SEL_KEY_DATA;
      else if (ofs == WIN_BITS'(OFS_DSP_STAT)) dec.sel = SEL_DSP_STAT;
      else if (ofs == WIN_BITS'(OFS_DSP_DATA)) dec.sel = SEL_DSP_DATA;
      else                                     dec.sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/conio_key_hold.sv
module conio_key_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [BYTE_W-1:0] held
);

  logic              full_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (in_valid && !full_q) begin
        full_q <= 1'b1;
        byte_q <= in_byte;
      end else if (take && full_q) begin
        full_q <= 1'b0;
      end
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign held     = byte_q;

endmodule

// File: rtl/conio_dsp_hold.sv
module conio_dsp_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              out_ready,
  output logic              pending
);

  logic              pend_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (pend_q && out_ready) begin
        pend_q <= 1'b0;
      end else if (load && !pend_q) begin
        pend_q <= 1'b1;
        byte_q <= load_byte;
      end
    end
  end

  assign out_valid = pend_q;
  assign out_byte  = byte_q;
  assign pending   = pend_q;

endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import conio_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              kbd_valid,
  input  logic [BYTE_W-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              dsp_valid,
  output logic [BYTE_W-1:0] dsp_data,
  input  logic              dsp_ready
);

  localparam int PAD_W = DATA_W - BYTE_W;

  decode_t           dec;
  logic              rd_io, wr_io, rd_mem, wr_mem;
  logic              key_full, dsp_pend;
  logic [BYTE_W-1:0] key_byte;
  logic [DATA_W-1:0] rd_mux;

  conio_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
    .addr (cpu_addr),
    .dec  (dec)
  );

  assign rd_io  = cpu_rd &&  dec.in_window;
  assign wr_io  = cpu_wr &&  dec.in_window;
  assign rd_mem = cpu_rd && !dec.in_window;
  assign wr_mem = cpu_wr && !dec.in_window;

  conio_key_hold #(.BYTE_W(BYTE_W)) u_key (
    .clk      (clk),
    .rst      (rst),
    .in_valid (kbd_valid),
    .in_byte  (kbd_data),
    .in_ready (kbd_ready),
    .take     (rd_io && dec.sel == SEL_KEY_DATA),
    .full     (key_full),
    .held     (key_byte)
  );

  conio_dsp_hold #(.BYTE_W(BYTE_W)) u_dsp (
    .clk       (clk),
    .rst       (rst),
    .load      (wr_io && dec.sel == SEL_DSP_DATA),
    .load_byte (cpu_wdata[BYTE_W-1:0]),
    .out_valid (dsp_valid),
    .out_byte  (dsp_data),
    .out_ready (dsp_ready),
    .pending   (dsp_pend)
  );

  always_comb begin
    rd_mux = '0;
    unique case (dec.sel)
      SEL_KEY_STAT: rd_mux = DATA_W'(key_full);
      SEL_KEY_DATA: rd_mux = key_full ? {{PAD_W{1'b0}}, key_byte} : '0;
      SEL_DSP_STAT: rd_mux = DATA_W'(!dsp_pend);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      io_rd     <= 1'b0;
      io_rdata  <= '0;
    end else begin
      mem_rd <= rd_mem;
      mem_wr <= wr_mem;
      if (rd_mem || wr_mem) mem_addr <= cpu_addr;
      if (wr_mem)           mem_wdata <= cpu_wdata;
      io_rd    <= rd_io;
      io_rdata <= rd_io ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int WIN_BITS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic              kbd_valid,
  input logic              kbd_ready,
  input logic              dsp_valid,
  input logic [BYTE_W-1:0] dsp_data,
  input logic              dsp_ready
);

  logic win;
  logic key_data_rd;
  assign win         = &cpu_addr[ADDR_W-1:WIN_BITS];
  assign key_data_rd = cpu_rd && win && (cpu_addr[WIN_BITS-1:0] == WIN_BITS'(4));

  // R1
  win_rd_io_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && win) |=> (io_rd && !mem_rd));

  // R1
  win_wr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && win) |=> !mem_wr);

  // R2
  mem_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !win) |=> (mem_rd && !io_rd && mem_addr == $past(cpu_addr)));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> (io_rdata == '0));

  // R3
  byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
    io_rd |-> (io_rdata[DATA_W-1:BYTE_W] == '0));

  // R5
  key_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (kbd_valid && kbd_ready) |=> !kbd_ready);

  // R5
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!kbd_ready && !key_data_rd) |=> !kbd_ready);

  // R6
  dsp_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data)));

endmodule

bind console_mmio console_mmio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .io_rd(io_rd),
  .io_rdata(io_rdata), .kbd_valid(kbd_valid), .kbd_ready(kbd_ready),
  .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready)
);

// File: tb/test_console_mmio.sv
`timescale 1ns/100ps
module test_console_mmio;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        mem_rd, mem_wr, io_rd;
  logic [31:0] mem_addr, mem_wdata, io_rdata;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_data = '0;
  logic        kbd_ready, dsp_valid;
  logic [7:0]  dsp_data;
  logic        dsp_ready = 1'b0;

  int vectors = 0;
  int errors  = 0;
  bit started = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  console_mmio i_console_mmio (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .kbd_ready(kbd_ready),
    .dsp_valid(dsp_valid), .dsp_data(dsp_data), .dsp_ready(dsp_ready)
  );

  // Behavioural reference model
  bit        m_mem_rd, m_mem_wr, m_io_rd;
  bit [31:0] m_mem_addr, m_mem_wdata, m_io_rdata;
  bit        m_full, m_pend;
  bit [7:0]  m_key, m_obyte;

  always @(posedge clk) begin
    bit        win, full_old, pend_old;
    bit [15:0] ofs;
    started = 1'b1;
    if (rst) begin
      m_mem_rd = 0; m_mem_wr = 0; m_io_rd = 0;
      m_mem_addr = 0; m_mem_wdata = 0; m_io_rdata = 0;
      m_full = 0; m_pend = 0; m_key = 0; m_obyte = 0;
    end else begin
      win      = (cpu_addr[31:16] == 16'hffff);
      ofs      = cpu_addr[15:0];
      full_old = m_full;
      pend_old = m_pend;
      m_mem_rd = cpu_rd && !win;
      m_mem_wr = cpu_wr && !win;
      if (!win && (cpu_rd || cpu_wr)) m_mem_addr = cpu_addr;
      if (!win && cpu_wr) m_mem_wdata = cpu_wdata;
      m_io_rd = cpu_rd && win;
      m_io_rdata = 0;
      if (cpu_rd && win) begin
        if (ofs == 16'h0000) m_io_rdata = {31'd0, full_old};
        else if (ofs == 16'h0004) m_io_rdata = full_old ? {24'd0, m_key} : 32'd0;
        else if (ofs == 16'h0008) m_io_rdata = {31'd0, !pend_old};
      end
      if (kbd_valid && !full_old) begin
        m_full = 1; m_key = kbd_data;
      end else if (cpu_rd && win && ofs == 16'h0004 && full_old) begin
        m_full = 0;
      end
      if (pend_old && dsp_ready) begin
        m_pend = 0;
      end else if (cpu_wr && win && ofs == 16'h000c && !pend_old) begin
        m_pend = 1; m_obyte = cpu_wdata[7:0];
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1/R2", "mem_rd", 32'(mem_rd), 32'(m_mem_rd));
      chk("R1/R2", "mem_wr", 32'(mem_wr), 32'(m_mem_wr));
      chk("R2", "mem_addr", mem_addr, m_mem_addr);
      chk("R2", "mem_wdata", mem_wdata, m_mem_wdata);
      chk("R1", "io_rd", 32'(io_rd), 32'(m_io_rd));
      chk("R3/R4/R10", "io_rdata", io_rdata, m_io_rdata);
      chk("R5", "kbd_ready", 32'(kbd_ready), 32'(!m_full));
      chk("R6", "dsp_valid", 32'(dsp_valid), 32'(m_pend));
      chk("R6/R7", "dsp_data", 32'(dsp_data), 32'(m_obyte));
    end
  end

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); d = io_rdata; cpu_rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic key_offer(input logic [7:0] b, input int cycles);
    @(negedge clk); kbd_valid = 1'b1; kbd_data = b;
    repeat (cycles) @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9", "kbd_ready", 32'(kbd_ready), 32'd1);
    chk("R9", "dsp_valid", 32'(dsp_valid), 32'd0);
    chk("R9", "io_rd", 32'(io_rd), 32'd0);
    chk("R9", "io_rdata", io_rdata, 32'd0);

    // R2 forwarding
    bus_rd(32'h0000_1000, d);
    bus_wr(32'h7fff_0004, 32'h1234_5678);
    chk("R2", "mem_wdata", mem_wdata, 32'h1234_5678);

    // R4 / R3 empty key register
    bus_rd(32'hffff_0000, d); chk("R4", "key status empty", d, 32'd0);
    bus_rd(32'hffff_0004, d); chk("R3", "key data empty", d, 32'd0);

    // R5 capture, refusal while full
    key_offer(8'ha5, 1);
    bus_rd(32'hffff_0000, d); chk("R4", "key status full", d, 32'd1);
    key_offer(8'h3c, 3);
    chk("R5", "kbd_ready while full", 32'(kbd_ready), 32'd0);
    // R8 store to key status has no effect
    bus_wr(32'hffff_0000, 32'h0);
    bus_rd(32'hffff_0000, d); chk("R8", "key status after store", d, 32'd1);
    bus_rd(32'hffff_0004, d); chk("R3", "key data kept", d, 32'h0000_00a5);
    bus_rd(32'hffff_0000, d); chk("R3", "status cleared by read", d, 32'd0);
    key_offer(8'h3c, 1);
    bus_rd(32'hffff_0004, d); chk("R5", "second key", d, 32'h0000_003c);

    // R6 / R7 display
    bus_rd(32'hffff_0008, d); chk("R6", "dsp status idle", d, 32'd1);
    bus_wr(32'hffff_000c, 32'h0000_01ff);
    chk("R6", "dsp_valid", 32'(dsp_valid), 32'd1);
    chk("R6", "dsp_data", 32'(dsp_data), 32'h0000_00ff);
    bus_rd(32'hffff_0008, d); chk("R6", "dsp status busy", d, 32'd0);
    bus_wr(32'hffff_000c, 32'h0000_0077);
    chk("R7", "dsp_data kept", 32'(dsp_data), 32'h0000_00ff);
    @(negedge clk); dsp_ready = 1'b1;
    @(negedge clk); dsp_ready = 1'b0;
    chk("R6", "dsp_valid after ack", 32'(dsp_valid), 32'd0);
    bus_rd(32'hffff_0008, d); chk("R6", "dsp status idle again", d, 32'd1);

    // R8 unmapped offsets
    bus_rd(32'hffff_000c, d); chk("R8", "dsp data read", d, 32'd0);
    bus_rd(32'hffff_0010, d); chk("R8", "offset 0x10", d, 32'd0);
    bus_rd(32'hffff_8000, d); chk("R8", "offset 0x8000", d, 32'd0);
    bus_wr(32'hffff_0008, 32'hffff_ffff);
    bus_wr(32'hffff_0044, 32'h0000_0011);
    chk("R8", "dsp_valid after stray stores", 32'(dsp_valid), 32'd0);

    // Random traffic, compared against the model every cycle
    for (int i = 0; i < 2000; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom_range(0, 7);
      case (sel)
        0: cpu_addr = 32'hffff_0000;
        1: cpu_addr = 32'hffff_0004;
        2: cpu_addr = 32'hffff_0008;
        3: cpu_addr = 32'hffff_000c;
        4: cpu_addr = 32'hffff_0000 | ($urandom & 32'h0000_ffff);
        default: cpu_addr = $urandom & 32'h7fff_fffc;
      endcase
      cpu_wdata = $urandom;
      sel = $urandom_range(0, 3);
      cpu_rd = (sel == 0);
      cpu_wr = (sel == 1);
      kbd_valid = ($urandom_range(0, 3) == 0);
      kbd_data  = 8'($urandom);
      dsp_ready = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; kbd_valid = 0; dsp_ready = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule